// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between the host bus and the embedded algorithm engine of a NOR-style flash device. It watches write cycles and recognises the multi-write command sequences that launch a program, erase a sector or the whole array, switch reads to the identification code register, or enter a persistent fast-program mode in which each program needs only two writes instead of four. It also tells the read path where read data comes from: the array, the code register, or the operation status bits while the engine is busy.

A write cycle is taken when the write strobe rises while chip enable is low. Only the low byte of the data bus carries command codes, and only the low eleven address bits are compared against the two unlock addresses. The decoder issues single-cycle start pulses with the captured program address and data, or the erase target. The engine that times the operation drives `busy` back. While `busy` is high the decoder ignores writes.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset no start pulse is asserted, `rd_src` is 0 (array) and `fast_mode` is 0.
- R2: A write is taken only on a rising edge of `we_n` while `ce_n` is low. A strobe edge with `ce_n` high has no effect on the decoder state.
- R3: Data 0xAA at address 0x555, then 0x55 at 0x2AA, then 0xA0 at 0x555, then any write, gives a one-cycle `pgm_start`. On that cycle `pgm_addr` and `pgm_data` hold the fourth write's address and data. Only `wdata[7:0]` and `addr[10:0]` are compared.
- R4: The two unlock writes, then 0x80 at 0x555, then the two unlock writes again, then 0x10 at 0x555, give `erase_start` with `erase_all` = 1. The same sequence with 0x30 as the last write, at any address, gives `erase_start` with `erase_all` = 0 and `erase_sector` equal to the top SECT_W address bits of that write.
- R5: The two unlock writes followed by 0x90 at 0x555 set `rd_src` to 1 (code register). Only a write of 0xF0 sets it back to 0. Other writes leave it at 1 and launch nothing.
- R6: The two unlock writes followed by 0x20 at 0x555 set `fast_mode` to 1. In fast mode, 0xA0 at any address followed by any write gives `pgm_start` with that write's address and data, and fast mode remains set afterwards. Fast mode never issues `erase_start`.
- R7: In fast mode, 0x90 followed by 0x00 clears `fast_mode`. If the write after 0x90 is not 0x00, fast mode stays set.
- R8: Outside fast mode and code mode, a write that does not match the next expected step sends the decoder back to idle, so a full sequence is needed again.
- R9: While `busy` is 1, `rd_src` is 2 (status) and writes are ignored: the decoder state does not change and no pulse is issued.
- R10: `pgm_start` and `erase_start` are never high together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low; a write is taken on its rising edge |
| addr | input | ADDR_W | Bus address |
| wdata | input | DATA_W | Bus write data; commands are in the low byte |
| busy | input | 1 | Embedded algorithm engine is running |
| pgm_start | output | 1 | One-cycle program launch |
| pgm_addr | output | ADDR_W | Address to program |
| pgm_data | output | DATA_W | Data to program |
| erase_start | output | 1 | One-cycle erase launch |
| erase_all | output | 1 | Erase targets the whole array |
| erase_sector | output | SECT_W | Sector to erase |
| rd_src | output | 2 | Read source: 0 array, 1 code register, 2 status |
| fast_mode | output | 1 | Two-write program mode is active |

## Verification
The bound checker tests properties that hold on every cycle. These are the mutual exclusion and one-cycle width of the start pulses, that no launch follows a cycle with `busy` high, that an erase never comes out of fast mode, that code reads and fast mode never overlap, and that the program address holds between launches. Only the bench scenarios can show that the sequence ordering is right. The bench sweeps every command byte in the third write, every sector in an erase, entry and exit of fast mode, mismatch recovery, and a program setup step that is held across a busy period.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_UNL1,
      ST_UNL2,
      ST_PGM,
      ST_ERS,
      ST_EUNL1,
      ST_EUNL2,
      ST_CODE,
      ST_FAST,
      ST_FPGM,
      ST_FEXIT
   } dec_state_t;

   typedef enum logic [1:0] {
      RD_ARRAY  = 2'd0,
      RD_CODE   = 2'd1,
      RD_STATUS = 2'd2
   } rd_src_t;

   localparam int NCMD  = 10;
   localparam int K_AA  = 0;
   localparam int K_55  = 1;
   localparam int K_A0  = 2;
   localparam int K_80  = 3;
   localparam int K_90  = 4;
   localparam int K_20  = 5;
   localparam int K_10  = 6;
   localparam int K_30  = 7;
   localparam int K_F0  = 8;
   localparam int K_00  = 9;

   function automatic logic [7:0] cmd_code(input int k);
      case (k)
         K_AA:    return 8'hAA;
         K_55:    return 8'h55;
         K_A0:    return 8'hA0;
         K_80:    return 8'h80;
         K_90:    return 8'h90;
         K_20:    return 8'h20;
         K_10:    return 8'h10;
         K_30:    return 8'h30;
         K_F0:    return 8'hF0;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/flcmd_strobe.sv
module flcmd_strobe #(
   parameter bit ON_RISE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic we_n,
   output logic evt
);

   logic we_q;

   always_ff @(posedge clk) begin
      if (!rst_n) we_q <= 1'b1;
      else        we_q <= we_n;
   end

   generate
      if (ON_RISE) begin : g_rise
         assign evt = ~ce_n & we_n & ~we_q;
      end else begin : g_fall
         assign evt = ~ce_n & ~we_n & we_q;
      end
   endgenerate

endmodule

// File: rtl/flcmd_match.sv
module flcmd_match
   import flcmd_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int CMP_W  = 11
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        cbyte,
   output logic [NCMD-1:0]   hit,
   output logic              at_555,
   output logic              at_2aa
);

   localparam logic [CMP_W-1:0] UNL_A1 = CMP_W'(11'h555);
   localparam logic [CMP_W-1:0] UNL_A2 = CMP_W'(11'h2AA);

   generate
      if (CMP_W < 11) begin : g_bad_cmp
         $error("CMP_W must cover the unlock addresses");
      end
      if (ADDR_W < CMP_W) begin : g_bad_addr
         $error("ADDR_W must be at least CMP_W");
      end
      for (genvar k = 0; k < NCMD; k++) begin : g_hit
         assign hit[k] = (cbyte == cmd_code(k));
      end
   endgenerate

   assign at_555 = (addr[CMP_W-1:0] == UNL_A1);
   assign at_2aa = (addr[CMP_W-1:0] == UNL_A2);

endmodule

// File: rtl/flcmd_fsm.sv
module flcmd_fsm
   import flcmd_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 16,
   parameter int SECT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [NCMD-1:0]   hit,
   input  logic              at_555,
   input  logic              at_2aa,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              pgm_start,
   output logic [ADDR_W-1:0] pgm_addr,
   output logic [DATA_W-1:0] pgm_data,
   output logic              erase_start,
   output logic              erase_all,
   output logic [SECT_W-1:0] erase_sector,
   output logic              fast_mode,
   output logic              code_mode
);

   dec_state_t state, nxt;
   logic       launch_p, launch_e, launch_all;

   always_comb begin
      nxt        = state;
      launch_p   = 1'b0;
      launch_e   = 1'b0;
      launch_all = 1'b0;
      if (go) begin
         case (state)
            ST_IDLE:  nxt = (hit[K_AA] && at_555) ? ST_UNL1 : ST_IDLE;
            ST_UNL1:  nxt = (hit[K_55] && at_2aa) ? ST_UNL2 : ST_IDLE;
            ST_UNL2: begin
               nxt = ST_IDLE;
               if (at_555) begin
                  if (hit[K_A0])      nxt = ST_PGM;
                  else if (hit[K_80]) nxt = ST_ERS;
                  else if (hit[K_90]) nxt = ST_CODE;
                  else if (hit[K_20]) nxt = ST_FAST;
               end
            end
            ST_PGM: begin
               launch_p = 1'b1;
               nxt      = ST_IDLE;
            end
            ST_ERS:   nxt = (hit[K_AA] && at_555) ? ST_EUNL1 : ST_IDLE;
            ST_EUNL1: nxt = (hit[K_55] && at_2aa) ? ST_EUNL2 : ST_IDLE;
            ST_EUNL2: begin
               nxt = ST_IDLE;
               if (hit[K_10] && at_555) begin
                  launch_e   = 1'b1;
                  launch_all = 1'b1;
               end else if (hit[K_30]) begin
                  launch_e   = 1'b1;
               end
            end
            ST_CODE:  nxt = hit[K_F0] ? ST_IDLE : ST_CODE;
            ST_FAST: begin
               if (hit[K_A0])      nxt = ST_FPGM;
               else if (hit[K_90]) nxt = ST_FEXIT;
            end
            ST_FPGM: begin
               launch_p = 1'b1;
               nxt      = ST_FAST;
            end
            ST_FEXIT: nxt = hit[K_00] ? ST_IDLE : ST_FAST;
            default:  nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         pgm_start    <= 1'b0;
         pgm_addr     <= '0;
         pgm_data     <= '0;
         erase_start  <= 1'b0;
         erase_all    <= 1'b0;
         erase_sector <= '0;
      end else begin
         state       <= nxt;
         pgm_start   <= launch_p;
         erase_start <= launch_e;
         if (launch_p) begin
            pgm_addr <= addr;
            pgm_data <= wdata;
         end
         if (launch_e) begin
            erase_all    <= launch_all;
            erase_sector <= addr[ADDR_W-1 -: SECT_W];
         end
      end
   end

   assign fast_mode = (state == ST_FAST) || (state == ST_FPGM) || (state == ST_FEXIT);
   assign code_mode = (state == ST_CODE);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import flcmd_pkg::*;
#(
   parameter int ADDR_W  = 19,
   parameter int DATA_W  = 16,
   parameter int SECT_W  = 4,
   parameter int CMP_W   = 11,
   parameter bit ON_RISE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              busy,
   output logic              pgm_start,
   output logic [ADDR_W-1:0] pgm_addr,
   output logic [DATA_W-1:0] pgm_data,
   output logic              erase_start,
   output logic              erase_all,
   output logic [SECT_W-1:0] erase_sector,
   output logic [1:0]        rd_src,
   output logic              fast_mode
);

   localparam int CMD_W = 8;

   generate
      if (DATA_W < CMD_W) begin : g_bad_data
         $error("DATA_W must hold a command byte");
      end
      if (SECT_W < 1 || SECT_W > ADDR_W) begin : g_bad_sect
         $error("SECT_W must lie within ADDR_W");
      end
   endgenerate

   logic            evt;
   logic [NCMD-1:0] hit;
   logic            at_555, at_2aa, code_mode;

   flcmd_strobe #(.ON_RISE(ON_RISE)) strobe_i (
      .clk   (clk),
      .rst_n (rst_n),
      .ce_n  (ce_n),
      .we_n  (we_n),
      .evt   (evt)
   );

   flcmd_match #(.ADDR_W(ADDR_W), .CMP_W(CMP_W)) match_i (
      .addr   (addr),
      .cbyte  (wdata[CMD_W-1:0]),
      .hit    (hit),
      .at_555 (at_555),
      .at_2aa (at_2aa)
   );

   flcmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) fsm_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .go           (evt & ~busy),
      .hit          (hit),
      .at_555       (at_555),
      .at_2aa       (at_2aa),
      .addr         (addr),
      .wdata        (wdata),
      .pgm_start    (pgm_start),
      .pgm_addr     (pgm_addr),
      .pgm_data     (pgm_data),
      .erase_start  (erase_start),
      .erase_all    (erase_all),
      .erase_sector (erase_sector),
      .fast_mode    (fast_mode),
      .code_mode    (code_mode)
   );

   always_comb begin
      if (busy)           rd_src = RD_STATUS;
      else if (code_mode) rd_src = RD_CODE;
      else                rd_src = RD_ARRAY;
   end

endmodule

// File: rtl/flcmd_chk.sv
module flcmd_chk #(
   parameter int ADDR_W = 19
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              pgm_start,
   input logic              erase_start,
   input logic              erase_all,
   input logic [ADDR_W-1:0] pgm_addr,
   input logic [1:0]        rd_src,
   input logic              fast_mode
);

   // R10
   start_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pgm_start && erase_start));

   // R10
   pgm_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_start |=> !pgm_start);

   // R10
   ers_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_start |=> !erase_start);

   // R4
   all_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_start && erase_all) |-> !pgm_start);

   // R9
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pgm_start || erase_start) |-> !$past(busy));

   // R6
   fast_no_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_start |-> !fast_mode);

   // R5
   code_fast_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fast_mode && rd_src == 2'd1));

   // R3
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pgm_start |-> $stable(pgm_addr));

endmodule

bind flash_cmd_decoder flcmd_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .pgm_start   (pgm_start),
   .erase_start (erase_start),
   .erase_all   (erase_all),
   .pgm_addr    (pgm_addr),
   .rd_src      (rd_src),
   .fast_mode   (fast_mode)
);

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;

   localparam int AW = 19;
   localparam int DW = 16;
   localparam int SW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1;
   logic          we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          busy = 1'b0;
   logic          pgm_start, erase_start, erase_all, fast_mode;
   logic [AW-1:0] pgm_addr;
   logic [DW-1:0] pgm_data;
   logic [SW-1:0] erase_sector;
   logic [1:0]    rd_src;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   int linger = 0;
   bit done   = 1'b0;

   logic          s_pgm, s_ers, s_all;
   logic [AW-1:0] s_pa;
   logic [DW-1:0] s_pd;
   logic [SW-1:0] s_sec;

   flash_cmd_decoder dut_i (
      .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .we_n (we_n),
      .addr (addr), .wdata (wdata), .busy (busy),
      .pgm_start (pgm_start), .pgm_addr (pgm_addr), .pgm_data (pgm_data),
      .erase_start (erase_start), .erase_all (erase_all),
      .erase_sector (erase_sector), .rd_src (rd_src), .fast_mode (fast_mode)
   );

   always #4 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         errors = errors + 1;
         $display("FAIL watchdog: run did not finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one bus write; samples the pulse outputs in the cycle after the strobe edge
   task automatic wr_ce(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic ce);
      @(negedge clk);
      addr = a; wdata = d; ce_n = ce; we_n = 1'b0;
      @(negedge clk);
      we_n = 1'b1;
      @(negedge clk);
      s_pgm = pgm_start; s_ers = erase_start; s_all = erase_all;
      s_pa = pgm_addr; s_pd = pgm_data; s_sec = erase_sector;
      ce_n = 1'b1;
      @(negedge clk);
      if (pgm_start || erase_start) linger++;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      wr_ce(a, d, 1'b0);
   endtask

   task automatic unlock();
      wr(19'h0555, 16'h00AA);
      wr(19'h02AA, 16'h0055);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 pgm_start", pgm_start, 0);
      chk("R1 erase_start", erase_start, 0);
      chk("R1 rd_src", rd_src, 0);
      chk("R1 fast_mode", fast_mode, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 four-write program, upper address and data bits ignored in matching
      wr(19'h7_8555, 16'h12AA);
      wr(19'h3_B2AA, 16'hFF55);
      wr(19'h0555, 16'h00A0);
      chk("R3 no early pulse", s_pgm, 0);
      wr(19'h4_1234, 16'hBEEF);
      chk("R3 pgm_start", s_pgm, 1);
      chk("R3 pgm_addr", s_pa, 19'h4_1234);
      chk("R3 pgm_data", s_pd, 16'hBEEF);
      chk("R10 erase quiet", s_ers, 0);

      // R2 write with ce_n high is ignored; setup state held
      unlock();
      wr(19'h0555, 16'h00A0);
      wr_ce(19'h0111, 16'h1111, 1'b1);
      chk("R2 ce high no launch", s_pgm, 0);
      wr(19'h0222, 16'h2222);
      chk("R2 held setup launches", s_pgm, 1);
      chk("R2 data", s_pd, 16'h2222);

      // R4 chip erase
      unlock(); wr(19'h0555, 16'h0080); unlock();
      wr(19'h0555, 16'h0010);
      chk("R4 chip start", s_ers, 1);
      chk("R4 chip all", s_all, 1);
      chk("R10 pgm quiet", s_pgm, 0);

      // R4 sector erase sweep
      for (int s = 0; s < (1 << SW); s++) begin
         unlock(); wr(19'h0555, 16'h0080); unlock();
         wr(AW'(s) << (AW - SW) | 19'h0123, 16'h0030);
         chk("R4 sector start", s_ers, 1);
         chk("R4 sector all", s_all, 0);
         chk("R4 sector id", s_sec, s);
      end

      // R5 code register mode
      unlock(); wr(19'h0555, 16'h0090);
      chk("R5 code src", rd_src, 1);
      wr(19'h0555, 16'h00A0);
      wr(19'h0010, 16'h3333);
      chk("R5 no launch", s_pgm, 0);
      chk("R5 still code", rd_src, 1);
      wr(19'h0000, 16'h00F0);
      chk("R5 back to array", rd_src, 0);

      // R6 fast program mode
      unlock(); wr(19'h0555, 16'h0020);
      chk("R6 fast set", fast_mode, 1);
      for (int i = 0; i < 3; i++) begin
         wr(19'h0000, 16'h00A0);
         chk("R6 no early pulse", s_pgm, 0);
         wr(AW'(19'h1_0000 + i * 19'h111), DW'(16'hC000 + i));
         chk("R6 pgm", s_pgm, 1);
         chk("R6 addr", s_pa, 19'h1_0000 + i * 19'h111);
         chk("R6 data", s_pd, 16'hC000 + i);
         chk("R6 stays fast", fast_mode, 1);
      end

      // R7 exit needs 0x90 then 0x00
      wr(19'h0000, 16'h0090);
      wr(19'h0000, 16'h0055);
      chk("R7 not exited", fast_mode, 1);
      wr(19'h0000, 16'h0090);
      wr(19'h0000, 16'h0000);
      chk("R7 exited", fast_mode, 0);
      wr(19'h0000, 16'h00A0);
      wr(19'h0040, 16'h4444);
      chk("R7 two writes no longer program", s_pgm, 0);

      // R8 mismatch returns to idle
      wr(19'h0555, 16'h00AA); wr(19'h02AB, 16'h0055);
      wr(19'h0555, 16'h00A0); wr(19'h0050, 16'h5555);
      chk("R8 bad unlock address", s_pgm, 0);
      unlock(); wr(19'h0555, 16'h00A1); wr(19'h0050, 16'h5555);
      chk("R8 bad command byte", s_pgm, 0);
      unlock(); wr(19'h0555, 16'h0080); wr(19'h0555, 16'h00AB);
      wr(19'h02AA, 16'h0055); wr(19'h0555, 16'h0010);
      chk("R8 broken erase", s_ers, 0);

      // R9 busy: status source, writes ignored
      unlock(); wr(19'h0555, 16'h00A0);
      busy = 1'b1;
      @(negedge clk);
      chk("R9 status src", rd_src, 2);
      wr(19'h0060, 16'h6666);
      chk("R9 ignored while busy", s_pgm, 0);
      busy = 1'b0;
      wr(19'h0070, 16'h7777);
      chk("R9 state held", s_pgm, 1);
      chk("R9 data", s_pd, 16'h7777);

      // sweep every third-write command byte
      for (int c = 0; c < 256; c++) begin
         unlock(); wr(19'h0555, DW'(c));
         chk("R5 sweep src", rd_src, (c == 8'h90) ? 1 : 0);
         chk("R6 sweep fast", fast_mode, (c == 8'h20) ? 1 : 0);
         wr(19'h0123, 16'h5A5A);
         chk("R3 sweep pgm", s_pgm, (c == 8'hA0) ? 1 : 0);
         chk("R8 sweep ers", s_ers, 0);
         if (c == 8'h90) wr(19'h0000, 16'h00F0);
         if (c == 8'h20) begin
            wr(19'h0000, 16'h0090); wr(19'h0000, 16'h0000);
         end
         chk("R8 sweep idle", {fast_mode, rd_src}, 0);
      end

      chk("R10 pulse width", linger, 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule